// File: doc/BRIEF.md
# Supervisor Trap Cause and Value Capture

This block keeps the two registers that describe the most recent exception taken into supervisor mode. One register holds the cause. The other holds a trap value whose meaning depends on the kind of exception. When the core takes a trap, it pulses a strobe together with the exception code, the faulting virtual address and the raw bits of the faulting instruction. On the next clock edge the block records the cause. It also picks the trap value: the faulting address, the instruction bits or zero, according to the class of the code.

A single software port lets privileged code read either register and overwrite it. Outside a trap or an explicit write, both registers keep their contents indefinitely. The parameters set the register width (`XLEN`), the instruction width (`ILEN`), the width of the code input and whether an illegal-instruction trap records the instruction bits or zero.

Top module: `sup_trap_record`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cause_o` and `tval_o` are zero.
- R2: A trap strobe whose code is legal (0 to 8, 12, 13 or 15) loads `cause_o` on the next edge with the code in the low bits and zeros in every other bit. The top bit is the interrupt flag, and it is written as 0.
- R3: For codes 0, 1, 3, 4, 5, 6, 7, 12, 13 and 15, `tval_o` receives `fault_addr`. These are the misaligned, access-fault, breakpoint and page-fault classes.
- R4: For code 2 (illegal instruction) with `ILL_INSN_TVAL`=1, `tval_o` receives `fault_insn` zero-extended to `XLEN`, or its low `XLEN` bits when `ILEN`>`XLEN`. With `ILL_INSN_TVAL`=0 it receives zero.
- R5: For code 8 (environment call), `tval_o` is written with zero.
- R6: A trap strobe with a reserved code (9, 10, 11, 14, or 16 and above) changes neither register.
- R7: With no trap strobe and no software write, both registers keep their values.
- R8: A software write with `csr_sel`=0 loads `csr_wdata` into the cause register, and with `csr_sel`=1 into the trap-value register, on the next edge.
- R9: `csr_rdata` shows the cause register when `csr_sel`=0 and the trap-value register when `csr_sel`=1, combinationally.
- R10: When a legal trap and a software write fall in the same cycle, the trap update is applied and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_vld | input | 1 | Trap taken this cycle |
| trap_code | input | CODE_W | Exception code |
| fault_addr | input | XLEN | Faulting virtual address |
| fault_insn | input | ILEN | Raw faulting instruction bits |
| csr_wr_en | input | 1 | Software write strobe |
| csr_sel | input | 1 | 0 selects the cause register, 1 the trap-value register |
| csr_wdata | input | XLEN | Software write data |
| csr_rdata | output | XLEN | Selected register contents |
| cause_o | output | XLEN | Cause register |
| tval_o | output | XLEN | Trap-value register |

## Verification
Every value of the 5-bit code input is swept with a different address and instruction word each time. This tells the address, instruction and zero sources apart, and shows that reserved codes leave earlier contents untouched. Idle cycles between traps show that values are held. Software writes alone exercise the write and read paths. Writes that coincide with a legal trap, and with a reserved-code trap, show that the trap wins in the first case and that the write lands in the second. An environment call that follows a nonzero trap value shows that the register is truly cleared rather than held.

// File: rtl/strec_pkg.sv
package strec_pkg;
   typedef enum logic [1:0] {
      TV_ADDR = 2'd0,
      TV_INSN = 2'd1,
      TV_ZERO = 2'd2
   } tv_src_e;

   typedef struct packed {
      logic    legal;
      tv_src_e src;
   } code_class_t;
endpackage

// File: rtl/strec_code_class.sv
module strec_code_class
   import strec_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic [CODE_W-1:0] code,
   output code_class_t       cls
);
   logic upper_clear;

   generate
      if (CODE_W > 4) begin : g_wide
         assign upper_clear = ~|code[CODE_W-1:4];
      end else begin : g_narrow
         assign upper_clear = 1'b1;
      end
   endgenerate

   always_comb begin
      cls.legal = 1'b0;
      cls.src   = TV_ZERO;
      if (upper_clear) begin
         case (code[3:0])
            4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
            4'd12, 4'd13, 4'd15: begin
               cls.legal = 1'b1;
               cls.src   = TV_ADDR;
            end
            4'd2: begin
               cls.legal = 1'b1;
               cls.src   = TV_INSN;
            end
            4'd8: begin
               cls.legal = 1'b1;
               cls.src   = TV_ZERO;
            end
            default: begin
               cls.legal = 1'b0;
               cls.src   = TV_ZERO;
            end
         endcase
      end
   end
endmodule

// File: rtl/strec_tval_mux.sv
module strec_tval_mux
   import strec_pkg::*;
#(
   parameter int XLEN          = 64,
   parameter int ILEN          = 32,
   parameter bit ILL_INSN_TVAL = 1'b1
) (
   input  tv_src_e           src,
   input  logic [XLEN-1:0]   addr,
   input  logic [ILEN-1:0]   insn,
   output logic [XLEN-1:0]   tval_nxt
);
   logic [XLEN-1:0] insn_val;

   generate
      if (!ILL_INSN_TVAL) begin : g_insn_zero
         assign insn_val = '0;
      end else if (XLEN > ILEN) begin : g_insn_ext
         assign insn_val = {{(XLEN-ILEN){1'b0}}, insn};
      end else begin : g_insn_trunc
         assign insn_val = insn[XLEN-1:0];
      end
   endgenerate

   always_comb begin
      case (src)
         TV_ADDR: tval_nxt = addr;
         TV_INSN: tval_nxt = insn_val;
         default: tval_nxt = '0;
      endcase
   end
endmodule

// File: rtl/strec_regs.sv
module strec_regs #(
   parameter int XLEN   = 64,
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_take,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [XLEN-1:0]   tval_nxt,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [XLEN-1:0]   wr_data,
   output logic [XLEN-1:0]   cause_q,
   output logic [XLEN-1:0]   tval_q
);
   localparam int PAD_W = XLEN - CODE_W;

   logic [XLEN-1:0] cause_trap;
   assign cause_trap = {{PAD_W{1'b0}}, trap_code};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         tval_q  <= '0;
      end else if (trap_take) begin
         cause_q <= cause_trap;
         tval_q  <= tval_nxt;
      end else if (wr_en) begin
         if (wr_sel) tval_q  <= wr_data;
         else        cause_q <= wr_data;
      end
   end
endmodule

// File: rtl/sup_trap_record.sv
module sup_trap_record
   import strec_pkg::*;
#(
   parameter int XLEN          = 64,
   parameter int ILEN          = 32,
   parameter int CODE_W        = 5,
   parameter bit ILL_INSN_TVAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_vld,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [XLEN-1:0]   fault_addr,
   input  logic [ILEN-1:0]   fault_insn,
   input  logic              csr_wr_en,
   input  logic              csr_sel,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   output logic [XLEN-1:0]   cause_o,
   output logic [XLEN-1:0]   tval_o
);
   generate
      if (CODE_W < 4 || CODE_W >= XLEN) begin : g_bad_code_w
         $error("CODE_W must hold code 15 and leave the top cause bit free");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("XLEN too small");
      end
      if (ILEN < 16) begin : g_bad_ilen
         $error("ILEN too small");
      end
   endgenerate

   code_class_t     cls;
   logic [XLEN-1:0] tval_nxt;
   logic            trap_take;

   strec_code_class #(.CODE_W(CODE_W)) u_class (
      .code (trap_code),
      .cls  (cls)
   );

   strec_tval_mux #(
      .XLEN(XLEN), .ILEN(ILEN), .ILL_INSN_TVAL(ILL_INSN_TVAL)
   ) u_mux (
      .src      (cls.src),
      .addr     (fault_addr),
      .insn     (fault_insn),
      .tval_nxt (tval_nxt)
   );

   assign trap_take = trap_vld & cls.legal;

   strec_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .trap_take (trap_take),
      .trap_code (trap_code),
      .tval_nxt  (tval_nxt),
      .wr_en     (csr_wr_en),
      .wr_sel    (csr_sel),
      .wr_data   (csr_wdata),
      .cause_q   (cause_o),
      .tval_q    (tval_o)
   );

   assign csr_rdata = csr_sel ? tval_o : cause_o;
endmodule

// File: rtl/strec_chk.sv
module strec_chk #(
   parameter int XLEN          = 64,
   parameter int ILEN          = 32,
   parameter int CODE_W        = 5,
   parameter bit ILL_INSN_TVAL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trap_vld,
   input logic [CODE_W-1:0] trap_code,
   input logic [XLEN-1:0]   fault_addr,
   input logic              csr_wr_en,
   input logic              csr_sel,
   input logic [XLEN-1:0]   csr_wdata,
   input logic [XLEN-1:0]   cause_o,
   input logic [XLEN-1:0]   tval_o
);
   function automatic bit addr_cls(input logic [CODE_W-1:0] c);
      int v;
      v = int'(c);
      return (v <= 7 && v != 2) || v == 12 || v == 13 || v == 15;
   endfunction

   function automatic bit ok_code(input logic [CODE_W-1:0] c);
      int v;
      v = int'(c);
      return v <= 8 || v == 12 || v == 13 || v == 15;
   endfunction

   // R2
   p_cause_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_vld && ok_code(trap_code)) |=>
         (cause_o == XLEN'($past(trap_code)) && !cause_o[XLEN-1]));

   // R3
   p_addr_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_vld && addr_cls(trap_code)) |=> (tval_o == $past(fault_addr)));

   // R5
   p_ecall_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_vld && int'(trap_code) == 8) |=> (tval_o == '0));

   // R6
   p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_vld && !ok_code(trap_code) && !csr_wr_en) |=>
         ($stable(cause_o) && $stable(tval_o)));

   // R7
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_vld && !csr_wr_en) |=> ($stable(cause_o) && $stable(tval_o)));

   // R8
   p_sw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_vld && csr_wr_en && csr_sel) |=> (tval_o == $past(csr_wdata)));

   // R10
   p_trap_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_vld && ok_code(trap_code) && csr_wr_en && !csr_sel) |=>
         (cause_o == XLEN'($past(trap_code))));
endmodule

bind sup_trap_record strec_chk #(
   .XLEN(XLEN), .ILEN(ILEN), .CODE_W(CODE_W), .ILL_INSN_TVAL(ILL_INSN_TVAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trap_vld   (trap_vld),
   .trap_code  (trap_code),
   .fault_addr (fault_addr),
   .csr_wr_en  (csr_wr_en),
   .csr_sel    (csr_sel),
   .csr_wdata  (csr_wdata),
   .cause_o    (cause_o),
   .tval_o     (tval_o)
);

// File: tb/sim_sup_trap_record.sv
module sim_sup_trap_record;
   localparam int XLEN   = 64;
   localparam int ILEN   = 32;
   localparam int CODE_W = 5;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              trap_vld;
   logic [CODE_W-1:0] trap_code;
   logic [XLEN-1:0]   fault_addr;
   logic [ILEN-1:0]   fault_insn;
   logic              csr_wr_en;
   logic              csr_sel;
   logic [XLEN-1:0]   csr_wdata;
   logic [XLEN-1:0]   csr_rdata;
   logic [XLEN-1:0]   cause_o;
   logic [XLEN-1:0]   tval_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   sup_trap_record u0 (
      .clk(clk), .rst_n(rst_n), .trap_vld(trap_vld), .trap_code(trap_code),
      .fault_addr(fault_addr), .fault_insn(fault_insn), .csr_wr_en(csr_wr_en),
      .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .cause_o(cause_o), .tval_o(tval_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   bit    done  = 0;
   string tag_c = "R1";
   string tag_t = "R1";

   logic [XLEN-1:0] m_cause = '0;
   logic [XLEN-1:0] m_tval  = '0;

   function automatic bit legal(input int c);
      return c <= 8 || c == 12 || c == 13 || c == 15;
   endfunction

   // behavioural model, updated on each rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_cause = '0;
         m_tval  = '0;
      end else if (trap_vld && legal(int'(trap_code))) begin
         m_cause = XLEN'(int'(trap_code));
         if (int'(trap_code) == 2)      m_tval = XLEN'(fault_insn);
         else if (int'(trap_code) == 8) m_tval = '0;
         else                           m_tval = fault_addr;
      end else if (csr_wr_en) begin
         if (csr_sel) m_tval  = csr_wdata;
         else         m_cause = csr_wdata;
      end
   end

   task automatic cmp(input string tag, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      cmp(tag_c, "cause", cause_o, m_cause);
      cmp(tag_t, "tval", tval_o, m_tval);
      cmp("R9", "rdata", csr_rdata, csr_sel ? m_tval : m_cause);
   endtask

   // drive after a falling edge, compare at the next falling edge
   task automatic step(input bit tv, input int code, input bit we, input bit sel,
                       input logic [XLEN-1:0] wd);
      trap_vld   = tv;
      trap_code  = CODE_W'(code);
      csr_wr_en  = we;
      csr_sel    = sel;
      csr_wdata  = wd;
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      tag_c = "R7"; tag_t = "R7";
      step(0, 0, 0, 0, '0);
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      rst_n = 0; trap_vld = 0; trap_code = '0; fault_addr = '0;
      fault_insn = '0; csr_wr_en = 0; csr_sel = 0; csr_wdata = '0;
      // R1: reset holds both registers at zero, even against a trap strobe
      @(negedge clk);
      tag_c = "R1"; tag_t = "R1";
      step(1, 3, 0, 0, '0);
      step(0, 0, 1, 1, 64'hFFFF);
      rst_n = 1;
      tag_c = "R1"; tag_t = "R1";
      step(0, 0, 0, 1, '0);
      idle();

      // sweep all codes: R2 cause, R3/R4/R5 value source, R6 reserved
      for (int c = 0; c < (1 << CODE_W); c++) begin
         fault_addr = {32'hA5A5_0000 + 32'(c), 32'h1000 + 32'(c * 8)};
         fault_insn = 32'h0000_7000 ^ 32'(c * 32'h0101_0103);
         if (legal(c)) tag_c = "R2"; else tag_c = "R6";
         if (!legal(c))   tag_t = "R6";
         else if (c == 2) tag_t = "R4";
         else if (c == 8) tag_t = "R5";
         else             tag_t = "R3";
         step(1, c, 0, c[0], '0);
         idle();
      end

      // R8/R9: software writes and reads of both registers
      tag_c = "R8"; tag_t = "R8";
      step(0, 0, 1, 0, 64'h8000_0000_0000_0009);
      step(0, 0, 1, 1, 64'hDEAD_BEEF_0123_4567);
      tag_c = "R9"; tag_t = "R9";
      step(0, 0, 0, 0, '0);
      step(0, 0, 0, 1, '0);
      idle();

      // R5: ecall clears a nonzero value
      tag_c = "R2"; tag_t = "R5";
      step(1, 8, 0, 1, '0);

      // R6: reserved trap with a write still lets the write land
      tag_c = "R6"; tag_t = "R6";
      fault_addr = 64'h1111_2222_3333_4444;
      step(1, 14, 1, 1, 64'h0BAD_CAFE);
      step(1, 10, 1, 0, 64'h55);

      // R10: legal trap wins over a same-cycle write
      tag_c = "R10"; tag_t = "R10";
      fault_addr = 64'h0000_7777_8888_9999;
      step(1, 13, 1, 0, 64'hFFFF_0000);
      step(1, 5, 1, 1, 64'hFFFF_1111);
      fault_insn = 32'hFFFF_FFFF;
      tag_t = "R4";
      step(1, 2, 1, 1, 64'h1234);
      idle();
      idle();

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule